// File: doc/BRIEF.md
# Power-On Strap Configuration Latch

This block reads the configuration of a clock generator from four shared pads that carry clocks once power-up is over. While power-on reset is held, the pads act as inputs. The block keeps sampling their resolved levels, so board pull-ups, pull-downs and undriven pins all count. After reset is released, the block stores the code taken at the first reference-clock edge. One cycle later it turns the pads into outputs, so the pads are never sampled and driven in the same cycle.

The stored code is turned into four settings: a CPU-rate index, a flag that picks a synchronous or an asynchronous bus clock, a production test-mode flag, and a global tristate flag that disables every clock output. Until the pads are turned around, all settings sit at a safe default with tristate asserted. The stored code does not change again until the next power-on reset.

Top module: `strap_cfg_latch`

## Requirements
- R1: While rst_ni is low, pad_oe_o is 0, tristate_o is 1, and test_mode_o, bus_sync_o and cpu_rate_o are all 0.
- R2: The pad bit map is: bit 0 is the bus select, bit 1 is FS0, bit 2 is FS1 and bit 3 is FS2. A pad marked undriven in pad_hiz_i reads as logic 1, whatever pad_lvl_i shows for it.
- R3: The stored code is the resolved pad level at the first rising clock edge after rst_ni goes high. Levels seen at earlier edges during reset are overwritten.
- R4: Changes on pad_lvl_i and pad_hiz_i after the capture edge have no effect on any output until the next reset.
- R5: All four bits of pad_oe_o rise together at the second rising edge after release, one cycle after capture. They stay high until reset.
- R6: For FS2..FS0 = 000, 100, 001, 010, 101 and 110, cpu_rate_o is 0, 1, 2, 3, 4 and 5 in that order. These are the rates 50, 55, 60, 66.6, 75 and 83.3 MHz ranked from slowest to fastest.
- R7: FS2..FS0 = 011 gives test_mode_o = 1, tristate_o = 0 and cpu_rate_o = 0.
- R8: FS2..FS0 = 111 gives tristate_o = 1, test_mode_o = 0, bus_sync_o = 0 and cpu_rate_o = 0.
- R9: For every code other than 111, bus_sync_o equals the stored bus select bit. A 1 selects a synchronous bus clock at half the CPU rate; a 0 selects the fixed 32 MHz asynchronous bus clock.
- R10: The decoded outputs change from the safe default at the same edge where pad_oe_o rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_lvl_i | input | 4 | Level seen at each shared pad |
| pad_hiz_i | input | 4 | Pad not driven by the board (pull-up wins) |
| pad_oe_o | output | 4 | Output enable for each shared pad |
| cpu_rate_o | output | 3 | CPU rate index, slowest is 0 |
| bus_sync_o | output | 1 | 1: bus clock at half CPU rate, 0: fixed async rate |
| test_mode_o | output | 1 | Production test mode selected |
| tristate_o | output | 1 | Disable all clock outputs |

## Verification
The bench sweeps every combination of pad level and undriven mask. A design that ignored the pull-up would decode the wrong code for floating pins. The bench moves the pads in the cycle just after capture and again after turnaround. A design that kept sampling would have its settings drift, and one that captured one edge late would latch the wrong value. It also checks outputs in the gap cycle between capture and turnaround. A design that drove the pads or released tristate early would show a non-zero enable or a decoded value there. The two special codes are checked for flag exclusivity and forced rate. A decoder that let the bus select leak through under tristate would show a synchronous bus flag.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_W    = 3;
  localparam int STRAP_W = FS_W + 1;
  localparam int RATE_W  = 3;

  localparam logic [FS_W-1:0] FS_TEST = 3'b011;
  localparam logic [FS_W-1:0] FS_TRI  = 3'b111;

  typedef struct packed {
    logic [FS_W-1:0] fs;       // FS2..FS0
    logic            bus_sel;
  } strap_t;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              bus_sync;
    logic              test_mode;
    logic              tristate;
  } cfg_t;

  localparam cfg_t CFG_SAFE = '{rate: '0, bus_sync: 1'b0, test_mode: 1'b0, tristate: 1'b1};

  function automatic cfg_t decode_strap(strap_t s);
    cfg_t c;
    c = '{rate: '0, bus_sync: s.bus_sel, test_mode: 1'b0, tristate: 1'b0};
    case (s.fs)
      3'b000: c.rate = 3'd0;
      3'b100: c.rate = 3'd1;
      3'b001: c.rate = 3'd2;
      3'b010: c.rate = 3'd3;
      3'b101: c.rate = 3'd4;
      3'b110: c.rate = 3'd5;
      FS_TEST: c.test_mode = 1'b1;
      default: c = CFG_SAFE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_en_i,
  input  logic [STRAP_W-1:0] pad_lvl_i,
  input  logic [STRAP_W-1:0] pad_hiz_i,
  output strap_t             code_o
);
  logic [STRAP_W-1:0] res;
  logic [STRAP_W-1:0] code_q;

  // internal pull-up: floating pad resolves high
  for (genvar b = 0; b < STRAP_W; b++) begin : g_pull
    assign res[b] = pad_hiz_i[b] | pad_lvl_i[b];
  end

  // no reset: capture must run while reset is held
  always_ff @(posedge clk_i) begin
    if (cap_en_i) code_q <= res;
  end

  assign code_o = strap_t'(code_q);

  AST_CODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(code_q)); // R4
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               cap_en_o,
  output logic               load_o,
  output logic [STRAP_W-1:0] pad_oe_o
);
  logic rel_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      rel_q <= 1'b1;
      oe_q  <= rel_q;
    end
  end

  assign cap_en_o = ~rel_q;
  assign load_o   = rel_q & ~oe_q;
  assign pad_oe_o = {STRAP_W{oe_q}};

  AST_OE_AFTER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(rel_q)); // R5
  AST_OE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |=> oe_q); // R5
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  strap_t code_i,
  output cfg_t   cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_SAFE;
    else if (load_i) cfg_q <= decode_strap(code_i);
  end

  assign cfg_o = cfg_q;

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_q.test_mode, cfg_q.tristate})); // R8
  AST_TRI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.tristate |-> (!cfg_q.bus_sync && cfg_q.rate == '0)); // R8
  AST_TEST_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.test_mode |-> cfg_q.rate == '0); // R7
endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] pad_lvl_i,
  input  logic [STRAP_W-1:0] pad_hiz_i,
  output logic [STRAP_W-1:0] pad_oe_o,
  output logic [RATE_W-1:0]  cpu_rate_o,
  output logic               bus_sync_o,
  output logic               test_mode_o,
  output logic               tristate_o
);
  logic   cap_en, load;
  strap_t code;
  cfg_t   cfg;

  strap_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_o (cap_en),
    .load_o   (load),
    .pad_oe_o (pad_oe_o)
  );

  strap_sampler u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_i  (cap_en),
    .pad_lvl_i (pad_lvl_i),
    .pad_hiz_i (pad_hiz_i),
    .code_o    (code)
  );

  strap_decode u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .code_i (code),
    .cfg_o  (cfg)
  );

  assign cpu_rate_o  = cfg.rate;
  assign bus_sync_o  = cfg.bus_sync;
  assign test_mode_o = cfg.test_mode;
  assign tristate_o  = cfg.tristate;

  AST_SAFE_UNTIL_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[0] |-> tristate_o); // R10
  AST_TRI_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o[0] && code.fs == FS_TRI) |-> tristate_o); // R8
  AST_TEST_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o[0] && code.fs == FS_TEST) |-> test_mode_o); // R7
endmodule

// File: tb/strap_cfg_latch_tb.sv
module strap_cfg_latch_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pad_lvl_i = 4'h0;
  logic [3:0] pad_hiz_i = 4'h0;
  logic [3:0] pad_oe_o;
  logic [2:0] cpu_rate_o;
  logic       bus_sync_o, test_mode_o, tristate_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  strap_cfg_latch u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pad_lvl_i   (pad_lvl_i),
    .pad_hiz_i   (pad_hiz_i),
    .pad_oe_o    (pad_oe_o),
    .cpu_rate_o  (cpu_rate_o),
    .bus_sync_o  (bus_sync_o),
    .test_mode_o (test_mode_o),
    .tristate_o  (tristate_o)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mhz10(int fs);
    case (fs)
      0: return 500; 1: return 600; 2: return 666;
      4: return 550; 5: return 750; 6: return 833;
      default: return 0;
    endcase
  endfunction

  function automatic int rank(int fs);
    int r = 0;
    for (int j = 0; j < 8; j++)
      if (j != 3 && j != 7 && mhz10(j) < mhz10(fs)) r++;
    return r;
  endfunction

  task automatic check_cfg(string tag, int code);
    int fs = code >> 1;
    bit tri_e = (fs == 7);
    bit tst_e = (fs == 3);
    chk({tag, " R5 oe"}, pad_oe_o, 15);
    chk({tag, " R8 tristate"}, tristate_o, tri_e);
    chk({tag, " R7 test"}, test_mode_o, tst_e);
    chk({tag, " R9 bus_sync"}, bus_sync_o, tri_e ? 0 : (code & 1));
    chk({tag, " R6 rate"}, cpu_rate_o, (tri_e || tst_e) ? 0 : rank(fs));
  endtask

  task automatic run_one(logic [3:0] lvl, logic [3:0] hiz);
    int code = int'(lvl | hiz); // R2: floating pad reads 1
    @(negedge clk_i);
    rst_ni = 1'b0;
    pad_lvl_i = ~lvl; pad_hiz_i = 4'h0;
    @(negedge clk_i);
    chk("R1 oe", pad_oe_o, 0);
    chk("R1 tristate", tristate_o, 1);
    chk("R1 flags", {test_mode_o, bus_sync_o, cpu_rate_o}, 0);
    @(negedge clk_i);
    pad_lvl_i = lvl; pad_hiz_i = hiz;  // R3: value at first edge after release
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 oe gap", pad_oe_o, 0);
    chk("R10 safe gap", {tristate_o, test_mode_o, bus_sync_o, cpu_rate_o}, 32);
    pad_lvl_i = ~lvl; pad_hiz_i = ~hiz;
    @(negedge clk_i);
    check_cfg("R3", code);
    for (int k = 0; k < 3; k++) begin
      pad_lvl_i = 4'(k * 5); pad_hiz_i = 4'(k);
      @(negedge clk_i);
      check_cfg("R4", code);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++)
        run_one(4'(l), 4'(h));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule